// File: doc/BRIEF.md
# Audio/Video Source Routing Controller

This block sits between the two written control bytes of a five-source, two-output video and stereo audio switch and the analog switch fabric. From the control bytes it produces registered one-hot source selects for the composite video, Y/C video and audio paths of each output, an attenuation select for audio output 1 and a one-hot level select for the aspect-signalling DC driver. Output 1 picks its video and audio sources separately; output 2 uses one code for both.

In the reverse direction it packs the results of three S-video detect comparators and three pairs of aspect-ratio threshold comparators into two status bytes for read-back. An asynchronous external mute request is synchronised and silences the audio selects of both outputs while it is held; video routing is not touched by it.

Top module: `av_route_ctrl`

## Requirements
- R1: After reset every source select is 0, `yc1_comb` and `aud1_att` are 0, `dc_lvl` is 3'b100 and both status bytes are 0; each control-byte change shows on the outputs after exactly one rising clock edge.
- R2: A 3-bit source code c in 1..5 maps to one-hot select bit c-1 (bit 0 TV, bits 1..4 inputs 1..4); codes 0, 6 and 7 give an all-zero select (muted).
- R3: Output 1 video uses `ctl_a[5:3]` for `vid1_src` and output 1 audio uses `ctl_a[2:0]` for `aud1_src`, independently of each other.
- R4: Output 2 uses the single code `ctl_b[5:3]` for both `vid2_src` and `aud2_src`.
- R5: With the Y/C mode bit (`ctl_a[6]` for output 1, `ctl_b[6]` for output 2) at 1, codes 2, 3, 4 set Y/C select bits 0, 1, 2 and every other code gives 0; with it at 0 the Y/C select is 0.
- R6: With `ctl_a[6]` at 0, `yc1_comb` is 1 exactly when the output 1 video code is in 1..5 (comb-filter return path); with `ctl_a[6]` at 1 it is 0.
- R7: `aud1_att` follows `ctl_a[7]` (1 selects -6 dB on audio output 1).
- R8: DC level code `ctl_b[2:1]` drives one-hot `dc_lvl`: code 1 gives 3'b001 (0 V), code 2 gives 3'b010 (1.9 V), codes 0 and 3 give 3'b100 (4.5 V).
- R9: `mute_req` held high forces `aud1_src` and `aud2_src` to 0 from the third rising edge after it rises and releases them on the third edge after it falls; video selects are unaffected.
- R10: Status bits `stat_a[7:5]` and `stat_b[7:5]` both carry `sdet_gnd[0]`, `sdet_gnd[1]`, `sdet_gnd[2]` from bit 7 down, one edge after the inputs.
- R11: Aspect code n is 0 when neither threshold is crossed, 1 when only `asp_lo_thr[n]` is high, 2 when `asp_hi_thr[n]` is high, and 3 whenever `sdet_open[n]` is high; codes for channels 0, 1, 2 sit in `stat_a[3:2]`, `stat_a[1:0]`, `stat_b[3:2]`.
- R12: Status bits `stat_a[4]`, `stat_b[4]` and `stat_b[1:0]` read 0, and control bits `ctl_b[7]` and `ctl_b[0]` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_a | input | 8 | Control byte for output 1 and audio gain |
| ctl_b | input | 8 | Control byte for output 2 and DC level |
| mute_req | input | 1 | Asynchronous audio mute request |
| sdet_gnd | input | 3 | S-detect comparators, 1 = pin grounded |
| sdet_open | input | 3 | S-detect pin open indicators |
| asp_lo_thr | input | 3 | Aspect pin above lower threshold |
| asp_hi_thr | input | 3 | Aspect pin above upper threshold |
| vid1_src | output | 5 | Composite video select, output 1 |
| yc1_src | output | 3 | Y/C select, output 1 |
| yc1_comb | output | 1 | Output 1 Y/C from comb-filter return |
| aud1_src | output | 5 | Audio select, output 1 |
| aud1_att | output | 1 | Audio output 1 -6 dB select |
| vid2_src | output | 5 | Composite video select, output 2 |
| yc2_src | output | 3 | Y/C select, output 2 |
| aud2_src | output | 5 | Audio select, output 2 |
| dc_lvl | output | 3 | One-hot DC level select |
| stat_a | output | 8 | Status byte 1 |
| stat_b | output | 8 | Status byte 2 |

## Verification
The assertions assume the two aspect thresholds form a thermometer code, so the upper comparator is never high while the lower one is low, and that an open S-detect pin is not also reported as grounded. The directed stimulus only ever applies threshold pairs of 00, 01 and 11 and sets an open flag only on a channel whose grounded flag is 0. Mute requests are held steady for several cycles so the synchroniser's window is always fully observed.

// File: rtl/av_route_ctrl.sv
module av_route_ctrl #(
  parameter int MUTE_SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] ctl_a,
  input  logic [7:0] ctl_b,
  input  logic       mute_req,
  input  logic [2:0] sdet_gnd,
  input  logic [2:0] sdet_open,
  input  logic [2:0] asp_lo_thr,
  input  logic [2:0] asp_hi_thr,
  output logic [4:0] vid1_src,
  output logic [2:0] yc1_src,
  output logic       yc1_comb,
  output logic [4:0] aud1_src,
  output logic       aud1_att,
  output logic [4:0] vid2_src,
  output logic [2:0] yc2_src,
  output logic [4:0] aud2_src,
  output logic [2:0] dc_lvl,
  output logic [7:0] stat_a,
  output logic [7:0] stat_b
);

  function automatic logic [4:0] src_hot(input logic [2:0] c);
    case (c)
      3'd1:    src_hot = 5'b00001;
      3'd2:    src_hot = 5'b00010;
      3'd3:    src_hot = 5'b00100;
      3'd4:    src_hot = 5'b01000;
      3'd5:    src_hot = 5'b10000;
      default: src_hot = 5'b00000;
    endcase
  endfunction

  function automatic logic [2:0] yc_hot(input logic [2:0] c, input logic sv);
    if (!sv) yc_hot = 3'b000;
    else begin
      case (c)
        3'd2:    yc_hot = 3'b001;
        3'd3:    yc_hot = 3'b010;
        3'd4:    yc_hot = 3'b100;
        default: yc_hot = 3'b000;
      endcase
    end
  endfunction

  function automatic logic [1:0] asp_code(input logic op, input logic lo, input logic hi);
    if (op)      asp_code = 2'd3;
    else if (hi) asp_code = 2'd2;
    else if (lo) asp_code = 2'd1;
    else         asp_code = 2'd0;
  endfunction

  logic [MUTE_SYNC-1:0] msync;
  logic                 mute_s;

  wire [2:0] v1c  = ctl_a[5:3];
  wire [2:0] a1c  = ctl_a[2:0];
  wire [2:0] av2c = ctl_b[5:3];
  wire       sv1  = ctl_a[6];
  wire       sv2  = ctl_b[6];

  assign mute_s = msync[MUTE_SYNC-1];

  logic [2:0] dc_nxt;
  always_comb begin
    case (ctl_b[2:1])
      2'd1:    dc_nxt = 3'b001;
      2'd2:    dc_nxt = 3'b010;
      default: dc_nxt = 3'b100;
    endcase
  end

  wire [1:0] sc0 = asp_code(sdet_open[0], asp_lo_thr[0], asp_hi_thr[0]);
  wire [1:0] sc1 = asp_code(sdet_open[1], asp_lo_thr[1], asp_hi_thr[1]);
  wire [1:0] sc2 = asp_code(sdet_open[2], asp_lo_thr[2], asp_hi_thr[2]);
  wire [2:0] gnd_rev = {sdet_gnd[0], sdet_gnd[1], sdet_gnd[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msync    <= '0;
      vid1_src <= '0;
      yc1_src  <= '0;
      yc1_comb <= 1'b0;
      aud1_src <= '0;
      aud1_att <= 1'b0;
      vid2_src <= '0;
      yc2_src  <= '0;
      aud2_src <= '0;
      dc_lvl   <= 3'b100;
      stat_a   <= '0;
      stat_b   <= '0;
    end else begin
      msync    <= {msync[MUTE_SYNC-2:0], mute_req};
      vid1_src <= src_hot(v1c);
      yc1_src  <= yc_hot(v1c, sv1);
      yc1_comb <= !sv1 && (src_hot(v1c) != 5'b0);
      aud1_src <= mute_s ? 5'b0 : src_hot(a1c);
      aud1_att <= ctl_a[7];
      vid2_src <= src_hot(av2c);
      yc2_src  <= yc_hot(av2c, sv2);
      aud2_src <= mute_s ? 5'b0 : src_hot(av2c);
      dc_lvl   <= dc_nxt;
      stat_a   <= {gnd_rev, 1'b0, sc0, sc1};
      stat_b   <= {gnd_rev, 1'b0, sc2, 2'b00};
    end
  end

endmodule

// File: rtl/av_route_ctrl_chk.sv
module av_route_ctrl_chk #(
  parameter int SYNC = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] ctl_a,
  input logic [7:0] ctl_b,
  input logic       mute_req,
  input logic [2:0] sdet_gnd,
  input logic [2:0] sdet_open,
  input logic [2:0] asp_lo_thr,
  input logic [2:0] asp_hi_thr,
  input logic [4:0] vid1_src,
  input logic [2:0] yc1_src,
  input logic       yc1_comb,
  input logic [4:0] aud1_src,
  input logic       aud1_att,
  input logic [4:0] vid2_src,
  input logic [2:0] yc2_src,
  input logic [4:0] aud2_src,
  input logic [2:0] dc_lvl,
  input logic [7:0] stat_a,
  input logic [7:0] stat_b
);

  logic [3:0] mute_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mute_run <= '0;
    else if (!mute_req) mute_run <= '0;
    else if (mute_run != 4'hF) mute_run <= mute_run + 4'd1;
  end

  assert_onehot_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vid1_src) && $onehot0(aud1_src) && $onehot0(vid2_src) && $onehot0(aud2_src));

  assert_shared_out2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (aud2_src != 5'b0) |-> (aud2_src == vid2_src));

  assert_comb_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(yc1_comb && (yc1_src != 3'b0)));

  assert_dc_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dc_lvl) == 1);

  assert_mute_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_run >= 4'(SYNC + 1)) |-> (aud1_src == 5'b0 && aud2_src == 5'b0));

  assert_gnd_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_a[7:5] == {$past(sdet_gnd[0]), $past(sdet_gnd[1]), $past(sdet_gnd[2])}));

  assert_open_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sdet_open[2] |=> (stat_b[3:2] == 2'd3));

  assert_blank_bits_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_a[4] && !stat_b[4] && (stat_b[1:0] == 2'b00) && (stat_a[7:5] == stat_b[7:5]));

endmodule

bind av_route_ctrl av_route_ctrl_chk #(.SYNC(MUTE_SYNC)) u_chk (.*);

// File: tb/av_route_ctrl_bench.sv
module av_route_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ctl_a = '0, ctl_b = '0;
  logic       mute_req = 1'b0;
  logic [2:0] sdet_gnd = '0, sdet_open = '0, asp_lo_thr = '0, asp_hi_thr = '0;
  logic [4:0] vid1_src, aud1_src, vid2_src, aud2_src;
  logic [2:0] yc1_src, yc2_src, dc_lvl;
  logic       yc1_comb, aud1_att;
  logic [7:0] stat_a, stat_b;
  int nrun = 0, nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  av_route_ctrl u_av_route_ctrl (.*);

  function automatic logic [4:0] e_src(input int c);
    return (c >= 1 && c <= 5) ? 5'(1 << (c - 1)) : 5'b0;
  endfunction
  function automatic logic [2:0] e_yc(input int c, input bit sv);
    return (sv && c >= 2 && c <= 4) ? 3'(1 << (c - 2)) : 3'b0;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nrun++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 vid1", 16'(vid1_src), 0); chk("R1 aud1", 16'(aud1_src), 0);
    chk("R1 out2", 16'({vid2_src, aud2_src, yc2_src}), 0);
    chk("R1 yc1", 16'({yc1_src, yc1_comb, aud1_att}), 0);
    chk("R1 dc", 16'(dc_lvl), 16'h4);
    chk("R1 stat", {stat_a, stat_b}, 0);
  endtask

  task automatic t_out1();
    for (int v = 0; v < 8; v++) begin
      int a = 7 - v;
      ctl_a = {2'b00, 3'(v), 3'(a)};
      step();
      chk("R2 R3 vid1", 16'(vid1_src), 16'(e_src(v)));
      chk("R3 aud1", 16'(aud1_src), 16'(e_src(a)));
    end
  endtask

  task automatic t_out2();
    for (int c = 0; c < 8; c++) begin
      ctl_b = {2'b00, 3'(c), 3'b000};
      step();
      chk("R4 vid2", 16'(vid2_src), 16'(e_src(c)));
      chk("R4 aud2", 16'(aud2_src), 16'(e_src(c)));
    end
  endtask

  task automatic t_yc();
    for (int c = 0; c < 8; c++) begin
      ctl_a = {2'b01, 3'(c), 3'b000}; ctl_b = {2'b01, 3'(c), 3'b000};
      step();
      chk("R5 yc1", 16'(yc1_src), 16'(e_yc(c, 1)));
      chk("R5 yc2", 16'(yc2_src), 16'(e_yc(c, 1)));
      chk("R6 comb off", 16'(yc1_comb), 0);
      ctl_a[6] = 1'b0; ctl_b[6] = 1'b0;
      step();
      chk("R5 yc composite", 16'({yc1_src, yc2_src}), 0);
      chk("R6 comb", 16'(yc1_comb), 16'(c >= 1 && c <= 5));
    end
  endtask

  task automatic t_gain();
    ctl_a = 8'h80; step(); chk("R7 att on", 16'(aud1_att), 1);
    ctl_a = 8'h00; step(); chk("R7 att off", 16'(aud1_att), 0);
  endtask

  task automatic t_dc();
    logic [2:0] ex [4] = '{3'b100, 3'b001, 3'b010, 3'b100};
    for (int d = 0; d < 4; d++) begin
      ctl_b = {5'b0, 2'(d), 1'b0};
      step();
      chk("R8 dc", 16'(dc_lvl), 16'(ex[d]));
    end
  endtask

  task automatic t_mute();
    ctl_a = {2'b00, 3'd1, 3'd2}; ctl_b = {2'b00, 3'd3, 3'b000};
    step();
    mute_req = 1'b1;
    step(); step();
    chk("R9 mute not yet", 16'({aud1_src, aud2_src}), 16'({e_src(2), e_src(3)}));
    step();
    chk("R9 muted", 16'({aud1_src, aud2_src}), 0);
    chk("R9 video kept", 16'({vid1_src, vid2_src}), 16'({e_src(1), e_src(3)}));
    mute_req = 1'b0;
    step(); step();
    chk("R9 still muted", 16'({aud1_src, aud2_src}), 0);
    step();
    chk("R9 released", 16'({aud1_src, aud2_src}), 16'({e_src(2), e_src(3)}));
  endtask

  task automatic t_status();
    sdet_gnd = 3'b101; sdet_open = 3'b000; asp_lo_thr = 3'b011; asp_hi_thr = 3'b001;
    step();
    chk("R10 R11 stat_a", 16'(stat_a), 16'hA9);
    chk("R10 R12 stat_b", 16'(stat_b), 16'hA0);
    sdet_gnd = 3'b001; sdet_open = 3'b110; asp_lo_thr = 3'b111; asp_hi_thr = 3'b000;
    step();
    chk("R11 open a", 16'(stat_a), 16'h87);
    chk("R11 open b", 16'(stat_b), 16'h8C);
    sdet_gnd = 3'b010; sdet_open = 3'b000; asp_lo_thr = 3'b100; asp_hi_thr = 3'b000;
    step();
    chk("R10 gnd mid", 16'(stat_a), 16'h40);
    chk("R11 lo only", 16'(stat_b), 16'h44);
  endtask

  task automatic t_ignored();
    ctl_b = {2'b00, 3'd4, 2'd2, 1'b0}; step();
    ctl_b = {2'b10, 3'd4, 2'd2, 1'b1}; step();
    chk("R12 ignored out2", 16'({vid2_src, aud2_src, yc2_src}), 16'({e_src(4), e_src(4), 3'b000}));
    chk("R12 ignored dc", 16'(dc_lvl), 16'h2);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_out1();
    t_out2();
    t_yc();
    t_gain();
    t_dc();
    t_mute();
    t_status();
    t_ignored();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule